// File: doc/BRIEF.md
# Transmit Equalizer Training Controller

This block steps a backplane lane's transmit equalizer through coefficient tuning together with a link partner. A training run works through three taps in a fixed order. Each tap goes through a series of steps, and every step is a four-phase exchange. First, the local receiver delivers its error-rate verdict. The controller then sends that verdict on as a request. Next, the partner's request for the local transmitter arrives and is applied through the reconfiguration strobe. Finally, an acknowledge pulse goes back. A tap is finished when it has seen enough hold verdicts or when its coefficient lands on a bound. The run ends in a done state after the last tap, or in a fail state if any awaited event misses its deadline.

A processor override path bypasses the sequencing. While override is enabled, a write loads all three coefficients and a tap selector directly and drives the same reconfiguration strobe. In daisy-chain mode, each outgoing request is marked for the next node on the ring instead of the node the data came from.

Top module: `lt_eq_ctrl`

## Requirements
- R1: After reset the strobe, request, acknowledge, done and fail outputs are low, and the three coefficient outputs equal the MAIN_INIT, POST_INIT and PRE_INIT parameters.
- R2: Command codes are 2'b01 increment, 2'b10 decrement, and 2'b00 or 2'b11 hold. An applied request changes only the coefficient of the tap being tuned, by +1, -1 or 0.
- R3: Increments saturate at coef_max and decrements saturate at coef_min; a coefficient never wraps.
- R4: Taps are tuned in the order main (tap code 0), then post (code 1), then pre (code 2). This code appears on out_req_tap and, while the strobe is high, on rc_tap.
- R5: A ber_valid accepted while waiting for a verdict gives a one-cycle out_req_valid on the next cycle, carrying ber_cmd. A following in_req_valid raises rc_start on the next cycle. An rc_done gives a one-cycle ack_o on the next cycle.
- R6: rc_start stays high until rc_done is seen, and only one update is outstanding at a time.
- R7: The controller moves to the next tap after HOLD_LIMIT hold requests on the current tap, or after an increment or decrement that leaves the coefficient equal to the bound in its direction.
- R8: train_done rises on the cycle after the acknowledge of the step that finishes the pre tap. train_done and train_fail are never high together.
- R9: If an awaited verdict, request or rc_done does not arrive within timeout_cyc cycles of entering the wait, train_fail rises after the timeout_cyc-th waiting cycle. A timeout_cyc of 0 disables the timeout.
- R10: While ovr_en is high, train_start is ignored. A proc_wr in an idle, done or fail state loads proc_main, proc_post and proc_pre and the tap selector (code 3 is treated as 2), then holds rc_start until rc_done.
- R11: out_req_fwd equals daisy_en at the time the verdict was accepted; 1 marks the request for the next node in the chain.
- R12: train_start in an idle, done or fail state reloads the initial coefficients, restarts at the main tap and clears done and fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| train_start | input | 1 | Begin a training run |
| daisy_en | input | 1 | Send requests to the next node in the chain |
| coef_min | input | CW | Lower coefficient bound |
| coef_max | input | CW | Upper coefficient bound |
| timeout_cyc | input | TW | Wait deadline in cycles, 0 disables |
| ber_valid | input | 1 | Local receiver verdict strobe |
| ber_cmd | input | 2 | Local receiver verdict command |
| out_req_valid | output | 1 | Outgoing request strobe |
| out_req_cmd | output | 2 | Outgoing request command |
| out_req_tap | output | 2 | Tap the outgoing request concerns |
| out_req_fwd | output | 1 | Request goes to the next node, not back |
| in_req_valid | input | 1 | Partner request strobe |
| in_req_cmd | input | 2 | Partner request command |
| ack_o | output | 1 | Acknowledge pulse to the partner |
| rc_start | output | 1 | Reconfiguration strobe, held until done |
| rc_main | output | CW | Main coefficient |
| rc_post | output | CW | Post-cursor coefficient |
| rc_pre | output | CW | Pre-cursor coefficient |
| rc_tap | output | 2 | Tap being updated |
| rc_done | input | 1 | Reconfiguration finished |
| ovr_en | input | 1 | Processor override enable |
| proc_wr | input | 1 | Processor coefficient write |
| proc_main | input | CW | Processor main value |
| proc_post | input | CW | Processor post value |
| proc_pre | input | CW | Processor pre value |
| proc_tap | input | 2 | Processor tap selector |
| train_done | output | 1 | Training finished |
| train_fail | output | 1 | Training timed out |

## Verification
The embedded assertions watch the cycle-level rules on every clock. They check that the strobe is held until done, that request and acknowledge pulses last one cycle, that coefficient steps never wrap, that done and fail are exclusive, that failure is entered only from a wait, and that the tap code stays in range. Only the bench's scenarios can show the arithmetic of each step, the tap order, the advance rule, the exact timeout cycle, the daisy-chain marking and the override loading. The bench sweeps command patterns, bounds and strobe delays against a step model it keeps itself.

// File: rtl/lt_pkg.sv
package lt_pkg;

   localparam logic [1:0] CMD_HOLD = 2'b00;
   localparam logic [1:0] CMD_INC  = 2'b01;
   localparam logic [1:0] CMD_DEC  = 2'b10;

   localparam logic [1:0] TAP_MAIN = 2'd0;
   localparam logic [1:0] TAP_POST = 2'd1;
   localparam logic [1:0] TAP_PRE  = 2'd2;

   typedef enum logic [2:0] {
      ST_IDLE, ST_EVAL, ST_REQW, ST_APPLY, ST_ACK, ST_DONE, ST_FAIL, ST_OVR
   } lt_state_e;

endpackage

// File: rtl/lt_coef_reg.sv
module lt_coef_reg #(
   parameter int CW   = 6,
   parameter int INIT = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_en,
   input  logic [CW-1:0] load_val,
   input  logic          step_en,
   input  logic [1:0]    cmd,
   input  logic [CW-1:0] lo,
   input  logic [CW-1:0] hi,
   output logic [CW-1:0] q,
   output logic          hit
);
   import lt_pkg::*;

   logic [CW-1:0] nxt;

   always_comb begin
      nxt = q;
      hit = 1'b0;
      case (cmd)
         CMD_INC: begin
            nxt = (q >= hi) ? hi : q + 1'b1;
            hit = (nxt == hi);
         end
         CMD_DEC: begin
            nxt = (q <= lo) ? lo : q - 1'b1;
            hit = (nxt == lo);
         end
         default: begin
            nxt = q;
            hit = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= CW'(INIT);
      else if (load_en) q <= load_val;
      else if (step_en) q <= nxt;
   end

   // R3: a step never wraps past the bound
   assert_inc_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_en && cmd == CMD_INC && q < hi) |=> (q > $past(q)));
   assert_dec_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_en && cmd == CMD_DEC && q > lo) |=> (q < $past(q)));

endmodule

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          run,
   input  logic [TW-1:0] limit,
   output logic          expire
);
   logic [TW-1:0] cnt;

   assign expire = run && (limit != '0) && (cnt == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 cnt <= '0;
      else if (clr)                               cnt <= '0;
      else if (run && limit != '0 && !expire)     cnt <= cnt + 1'b1;
   end

   // R9: the count never runs past the deadline
   assert_cnt_below_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr && limit != '0 && $stable(limit)) |=> (cnt < limit));

endmodule

// File: rtl/lt_eq_ctrl.sv
module lt_eq_ctrl #(
   parameter int CW         = 6,
   parameter int TW         = 16,
   parameter int HOLD_LIMIT = 3,
   parameter int MAIN_INIT  = 40,
   parameter int POST_INIT  = 0,
   parameter int PRE_INIT   = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          train_start,
   input  logic          daisy_en,
   input  logic [CW-1:0] coef_min,
   input  logic [CW-1:0] coef_max,
   input  logic [TW-1:0] timeout_cyc,
   input  logic          ber_valid,
   input  logic [1:0]    ber_cmd,
   output logic          out_req_valid,
   output logic [1:0]    out_req_cmd,
   output logic [1:0]    out_req_tap,
   output logic          out_req_fwd,
   input  logic          in_req_valid,
   input  logic [1:0]    in_req_cmd,
   output logic          ack_o,
   output logic          rc_start,
   output logic [CW-1:0] rc_main,
   output logic [CW-1:0] rc_post,
   output logic [CW-1:0] rc_pre,
   output logic [1:0]    rc_tap,
   input  logic          rc_done,
   input  logic          ovr_en,
   input  logic          proc_wr,
   input  logic [CW-1:0] proc_main,
   input  logic [CW-1:0] proc_post,
   input  logic [CW-1:0] proc_pre,
   input  logic [1:0]    proc_tap,
   output logic          train_done,
   output logic          train_fail
);
   import lt_pkg::*;

   localparam int NTAP = 3;
   localparam int HW   = $clog2(HOLD_LIMIT + 1);

   if (CW < 2) begin : g_bad_cw
      $error("lt_eq_ctrl: CW must be at least 2");
   end
   if (HOLD_LIMIT < 1) begin : g_bad_hold
      $error("lt_eq_ctrl: HOLD_LIMIT must be at least 1");
   end
   if (MAIN_INIT >= (1 << CW) || POST_INIT >= (1 << CW) || PRE_INIT >= (1 << CW))
   begin : g_bad_init
      $error("lt_eq_ctrl: an initial coefficient does not fit CW bits");
   end

   lt_state_e     state_q, state_d;
   logic [1:0]    tap_q, rc_tap_q;
   logic [HW-1:0] hold_q, hold_inc;
   logic          adv_q, adv_d;
   logic [CW-1:0] coef_q [NTAP];
   logic [CW-1:0] proc_v [NTAP];
   logic [3:0]    hit_w;
   logic          idle_like, go_train, go_ovr, waiting, event_w, expire, step_fire, is_hold;

   assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);
   assign go_train  = idle_like && !ovr_en && train_start;
   assign go_ovr    = idle_like && ovr_en && proc_wr;
   assign waiting   = (state_q == ST_EVAL) || (state_q == ST_REQW) || (state_q == ST_APPLY);
   assign event_w   = (state_q == ST_EVAL  && ber_valid)    ||
                      (state_q == ST_REQW  && in_req_valid) ||
                      (state_q == ST_APPLY && rc_done);
   assign step_fire = (state_q == ST_REQW) && in_req_valid;
   assign is_hold   = (in_req_cmd != CMD_INC) && (in_req_cmd != CMD_DEC);
   assign hold_inc  = hold_q + 1'b1;
   assign adv_d     = hit_w[tap_q] || (is_hold && hold_inc == HW'(HOLD_LIMIT));

   assign proc_v[0] = proc_main;
   assign proc_v[1] = proc_post;
   assign proc_v[2] = proc_pre;
   assign hit_w[3]  = 1'b0;

   for (genvar g = 0; g < NTAP; g++) begin : g_coef
      localparam int INIT_G = (g == 0) ? MAIN_INIT : (g == 1) ? POST_INIT : PRE_INIT;
      lt_coef_reg #(.CW(CW), .INIT(INIT_G)) u_coef (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_en  (go_train || go_ovr),
         .load_val (go_ovr ? proc_v[g] : CW'(INIT_G)),
         .step_en  (step_fire && tap_q == 2'(g)),
         .cmd      (in_req_cmd),
         .lo       (coef_min),
         .hi       (coef_max),
         .q        (coef_q[g]),
         .hit      (hit_w[g])
      );
   end

   lt_wait_timer #(.TW(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (state_d != state_q),
      .run    (waiting && !event_w),
      .limit  (timeout_cyc),
      .expire (expire)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE, ST_DONE, ST_FAIL: begin
            if (go_train)    state_d = ST_EVAL;
            else if (go_ovr) state_d = ST_OVR;
         end
         ST_EVAL:  if (ber_valid)    state_d = ST_REQW;  else if (expire) state_d = ST_FAIL;
         ST_REQW:  if (in_req_valid) state_d = ST_APPLY; else if (expire) state_d = ST_FAIL;
         ST_APPLY: if (rc_done)      state_d = ST_ACK;   else if (expire) state_d = ST_FAIL;
         ST_ACK:   state_d = (adv_q && tap_q == TAP_PRE) ? ST_DONE : ST_EVAL;
         ST_OVR:   if (rc_done)      state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         tap_q         <= TAP_MAIN;
         hold_q        <= '0;
         adv_q         <= 1'b0;
         rc_tap_q      <= TAP_MAIN;
         out_req_valid <= 1'b0;
         out_req_cmd   <= CMD_HOLD;
         out_req_tap   <= TAP_MAIN;
         out_req_fwd   <= 1'b0;
      end else begin
         state_q       <= state_d;
         out_req_valid <= (state_q == ST_EVAL) && ber_valid;
         if (state_q == ST_EVAL && ber_valid) begin
            out_req_cmd <= ber_cmd;
            out_req_tap <= tap_q;
            out_req_fwd <= daisy_en;
         end
         if (go_train) begin
            tap_q  <= TAP_MAIN;
            hold_q <= '0;
         end
         if (go_ovr) rc_tap_q <= (proc_tap == 2'd3) ? TAP_PRE : proc_tap;
         if (step_fire) begin
            adv_q    <= adv_d;
            rc_tap_q <= tap_q;
            if (is_hold) hold_q <= hold_inc;
         end
         if (state_q == ST_ACK && adv_q && tap_q != TAP_PRE) begin
            tap_q  <= tap_q + 1'b1;
            hold_q <= '0;
         end
      end
   end

   assign rc_start   = (state_q == ST_APPLY) || (state_q == ST_OVR);
   assign ack_o      = (state_q == ST_ACK);
   assign train_done = (state_q == ST_DONE);
   assign train_fail = (state_q == ST_FAIL);
   assign rc_main    = coef_q[0];
   assign rc_post    = coef_q[1];
   assign rc_pre     = coef_q[2];
   assign rc_tap     = rc_tap_q;

   // R6: strobe held until the reconfiguration side answers
   assert_start_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rc_start && !rc_done) |=> rc_start);
   // R5: request and acknowledge are single-cycle pulses
   assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_req_valid |=> !out_req_valid);
   assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);
   // R8: done and fail exclusive
   assert_done_fail_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(train_done && train_fail));
   // R9: failure is entered only from a wait
   assert_fail_from_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(train_fail) |-> $past(waiting));
   // R4: tap code in range while strobing
   assert_tap_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rc_start |-> (rc_tap != 2'd3));

endmodule

// File: tb/lt_eq_ctrl_bench.sv
module lt_eq_ctrl_bench;
   localparam int CW = 4, TW = 8, HL = 2;
   localparam int INIT_M = 10, INIT_P = 2, INIT_R = 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic train_start = 0, daisy_en = 0, ber_valid = 0, in_req_valid = 0, rc_done = 0;
   logic ovr_en = 0, proc_wr = 0;
   logic [CW-1:0] coef_min = 1, coef_max = 12, proc_main = 0, proc_post = 0, proc_pre = 0;
   logic [TW-1:0] timeout_cyc = 6;
   logic [1:0] ber_cmd = 0, in_req_cmd = 0, proc_tap = 0;
   logic out_req_valid, out_req_fwd, ack_o, rc_start, train_done, train_fail;
   logic [1:0] out_req_cmd, out_req_tap, rc_tap;
   logic [CW-1:0] rc_main, rc_post, rc_pre;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int em[3];
   int etap = 0, eholds = 0, edone = 0;

   always #10 clk = ~clk;

   lt_eq_ctrl #(.CW(CW), .TW(TW), .HOLD_LIMIT(HL), .MAIN_INIT(INIT_M),
                .POST_INIT(INIT_P), .PRE_INIT(INIT_R)) u_lt_eq_ctrl (
      .clk(clk), .rst_n(rst_n), .train_start(train_start), .daisy_en(daisy_en),
      .coef_min(coef_min), .coef_max(coef_max), .timeout_cyc(timeout_cyc),
      .ber_valid(ber_valid), .ber_cmd(ber_cmd), .out_req_valid(out_req_valid),
      .out_req_cmd(out_req_cmd), .out_req_tap(out_req_tap), .out_req_fwd(out_req_fwd),
      .in_req_valid(in_req_valid), .in_req_cmd(in_req_cmd), .ack_o(ack_o),
      .rc_start(rc_start), .rc_main(rc_main), .rc_post(rc_post), .rc_pre(rc_pre),
      .rc_tap(rc_tap), .rc_done(rc_done), .ovr_en(ovr_en), .proc_wr(proc_wr),
      .proc_main(proc_main), .proc_post(proc_post), .proc_pre(proc_pre),
      .proc_tap(proc_tap), .train_done(train_done), .train_fail(train_fail));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic chk_coefs(input string req);
      chk({req, " main"}, int'(rc_main), em[0]);
      chk({req, " post"}, int'(rc_post), em[1]);
      chk({req, " pre"},  int'(rc_pre),  em[2]);
   endtask

   task automatic begin_run();
      @(negedge clk) train_start = 1;
      @(negedge clk) train_start = 0;
      em[0] = INIT_M; em[1] = INIT_P; em[2] = INIT_R;
      etap = 0; eholds = 0; edone = 0;
      chk_coefs("R12 reload");
      chk("R12 done cleared", int'(train_done), 0);
      chk("R12 fail cleared", int'(train_fail), 0);
   endtask

   // one four-phase step; d = cycles of delay before rc_done
   task automatic do_step(input logic [1:0] cmd, input int d);
      int cur, nxt, lo, hi, hit, adv;
      @(negedge clk) begin ber_valid = 1; ber_cmd = cmd; end
      @(negedge clk) ber_valid = 0;
      chk("R5 request pulse", int'(out_req_valid), 1);
      chk("R5 request carries verdict", int'(out_req_cmd), int'(cmd));
      chk("R4 request tap", int'(out_req_tap), etap);
      chk("R11 forward flag", int'(out_req_fwd), int'(daisy_en));
      chk("R6 no strobe before request", int'(rc_start), 0);
      in_req_valid = 1; in_req_cmd = cmd;
      // model
      lo = int'(coef_min); hi = int'(coef_max); cur = em[etap]; hit = 0; nxt = cur;
      if (cmd == 2'b01) begin nxt = (cur >= hi) ? hi : cur + 1; hit = (nxt == hi); end
      else if (cmd == 2'b10) begin nxt = (cur <= lo) ? lo : cur - 1; hit = (nxt == lo); end
      else eholds++;
      em[etap] = nxt;
      adv = hit || ((cmd == 2'b00 || cmd == 2'b11) && eholds == HL);
      @(negedge clk) in_req_valid = 0;
      chk("R5 request single cycle", int'(out_req_valid), 0);
      chk("R5 strobe after request", int'(rc_start), 1);
      chk("R4 strobe tap", int'(rc_tap), etap);
      chk_coefs("R2 R3 step value");
      for (int k = 0; k < d; k++) begin
         @(negedge clk);
         chk("R6 strobe held", int'(rc_start), 1);
      end
      rc_done = 1;
      @(negedge clk) rc_done = 0;
      chk("R6 strobe dropped", int'(rc_start), 0);
      chk("R5 ack pulse", int'(ack_o), 1);
      if (adv) begin
         if (etap == 2) edone = 1;
         else begin etap++; eholds = 0; end
      end
      @(negedge clk);
      chk("R5 ack single cycle", int'(ack_o), 0);
      chk("R7 R8 done flag", int'(train_done), edone);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 strobe", int'(rc_start), 0);
      chk("R1 request", int'(out_req_valid), 0);
      chk("R1 ack", int'(ack_o), 0);
      chk("R1 done", int'(train_done), 0);
      chk("R1 fail", int'(train_fail), 0);
      em[0] = INIT_M; em[1] = INIT_P; em[2] = INIT_R;
      chk_coefs("R1 init");

      // directed run: main inc to max, post dec to min, pre two holds
      begin_run();
      do_step(2'b01, 0);
      do_step(2'b01, 1);
      chk("R7 moved to post after bound", etap, 1);
      do_step(2'b10, 2);
      chk("R7 moved to pre after bound", etap, 2);
      do_step(2'b00, 0);
      do_step(2'b11, 0);
      chk("R8 run finished", int'(train_done), 1);

      // sweep of command patterns, bounds, delays and chain mode
      for (int p = 0; p < 12; p++) begin
         coef_max = CW'(10 + p % 4);
         coef_min = CW'(p % 3);
         daisy_en = p[0];
         begin_run();
         for (int i = 0; i < 64 && edone == 0; i++)
            do_step(2'((i * (p + 1) + p) % 4), i % 3);
         chk("R8 sweep finished", int'(train_done), 1);
      end
      coef_min = 1; coef_max = 12; daisy_en = 0;

      // R9 disabled timeout
      timeout_cyc = 0;
      begin_run();
      repeat (40) @(negedge clk);
      chk("R9 zero timeout never fails", int'(train_fail), 0);
      do_step(2'b01, 0);

      // R9 timeout in verdict wait
      timeout_cyc = 6;
      do_step(2'b00, 0);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R9 not yet failed", int'(train_fail), 0);
      end
      @(negedge clk);
      chk("R9 fail after deadline", int'(train_fail), 1);
      chk("R8 no done with fail", int'(train_done), 0);

      // R10 override
      ovr_en = 1;
      @(negedge clk) train_start = 1;
      @(negedge clk) train_start = 0;
      chk("R10 start ignored in override", int'(train_fail), 1);
      chk("R10 no strobe from start", int'(rc_start), 0);
      proc_main = 7; proc_post = 3; proc_pre = 5; proc_tap = 1; proc_wr = 1;
      @(negedge clk) proc_wr = 0;
      em[0] = 7; em[1] = 3; em[2] = 5;
      chk("R10 strobe", int'(rc_start), 1);
      chk("R10 tap", int'(rc_tap), 1);
      chk_coefs("R10 loaded");
      repeat (3) begin
         @(negedge clk);
         chk("R10 R6 strobe held", int'(rc_start), 1);
      end
      rc_done = 1;
      @(negedge clk) rc_done = 0;
      chk("R10 strobe released", int'(rc_start), 0);
      chk("R10 fail cleared", int'(train_fail), 0);
      proc_main = 0; proc_post = 15; proc_pre = 9; proc_tap = 3; proc_wr = 1;
      @(negedge clk) proc_wr = 0;
      em[0] = 0; em[1] = 15; em[2] = 9;
      chk("R10 tap code 3 as pre", int'(rc_tap), 2);
      chk_coefs("R10 loaded again");
      rc_done = 1;
      @(negedge clk) rc_done = 0;
      ovr_en = 0;

      // R12 training resumes from initial values after override
      begin_run();
      do_step(2'b10, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule